// File: doc/BRIEF.md
# Flash Command Interpreter

This block sits on the device side of a flash memory zone and interprets bus write cycles as commands. It samples the chip-enable and write-enable strobes with the local clock. It captures the bus address when a qualified write-enable falls and the bus data when it rises. It then moves one mode machine per byte lane through read, program set-up, active program, program verify, erase set-up, active erase and erase verify.

Program and erase each take a two-write sequence. The second write of a program sequence carries the location and the data. The second write of an erase sequence confirms the erase. A one-cycle start pulse goes to the high-voltage sequencer, which lies outside this block. The next write, normally a verify command, ends the active operation. A per-lane select tells the read path to return margin-verify data.

In word-wide use every byte lane keeps its own command state and decodes only its own byte. A 16-bit write of 4040H therefore arms both lanes, while 2040H arms a program in the low lane and an erase in the high lane.

Top module: `flcmd_top`

## Requirements
- R1: After a synchronous reset every lane is in read mode (code 0), `verify_sel` is low and no start pulse is given.
- R2: A write counts only if write-enable falls while chip-enable is low and then rises while chip-enable is still low. A write-enable pulse with chip-enable high changes nothing. So does a cycle in which chip-enable rises before write-enable rises.
- R3: `lat_addr` takes `bus_addr` at each write-enable fall that happens with chip-enable low. `lat_data` takes `bus_din` at the rise that completes a write.
- R4: Byte 40H in read or a verify mode arms program set-up (code 1). The next write is program data, not a command. It enters active program (code 2) with one single-cycle `prog_start` pulse. If that next byte is FFH, set-up is cancelled back to read (code 0).
- R5: In active program, byte C0H enters program verify (code 3). Any other byte returns the lane to read (code 0).
- R6: Byte 20H in read or a verify mode arms erase set-up (code 4). A second 20H enters active erase (code 5) with one single-cycle `erase_start` pulse. Any other second byte returns to read with no pulse.
- R7: In active erase, byte A0H enters erase verify (code 6). Any other byte returns to read (code 0).
- R8: Byte 00H in read or a verify mode selects read (code 0). `verify_sel` of a lane is high exactly while that lane is in code 3 or 6.
- R9: Two completed writes in a row with byte FFH put the lane in read (code 0), whatever state it was in.
- R10: If `hv_ok` is low on the write that would start a program or erase, no start pulse is given and the lane returns to read (code 0).
- R11: Lane k decodes only `bus_din[8k+7:8k]`. Its mode appears on `lane_mode[3k+2:3k]`, its pulses on bit k of `prog_start` and `erase_start`.
- R12: In read or a verify mode, bytes other than 00H, 20H, 40H and FFH leave the lane mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low, asynchronous to clk |
| we_n | input | 1 | Write enable, active low, asynchronous to clk |
| bus_addr | input | ADDR_W | Bus address |
| bus_din | input | 8*LANES | Bus write data |
| hv_ok | input | 1 | High voltage present |
| lane_mode | output | 3*LANES | Mode code of each lane |
| prog_start | output | LANES | One-cycle program start per lane |
| erase_start | output | LANES | One-cycle erase start per lane |
| verify_sel | output | LANES | Read-path margin verify select per lane |
| lat_addr | output | ADDR_W | Latched write address |
| lat_data | output | 8*LANES | Latched write data |

## Verification
Directed sequences run the full program and erase flows on both lanes together. Mixed-lane words such as 2040H show that the lanes decode apart. Random streams draw every command byte and random data bytes per lane, with `hv_ok` sometimes low. They reach states that directed runs miss, such as an FFH following set-up or a verify command arriving in the wrong state. Address and data are each changed between the two write-enable edges, which separates capture on the fall from capture on the rise. Write-enable pulses with chip-enable high, and cycles cut short by chip-enable, show that unqualified cycles leave every output unchanged apart from the address latched at the fall.

// File: rtl/flcmd_pkg.sv
// Shared mode codes and command bytes for the flash command interpreter.
package flcmd_pkg;

    typedef enum logic [2:0] {
        MD_READ  = 3'd0,
        MD_PSET  = 3'd1,
        MD_PROG  = 3'd2,
        MD_PVFY  = 3'd3,
        MD_ESET  = 3'd4,
        MD_ERASE = 3'd5,
        MD_EVFY  = 3'd6
    } flmode_e;

    localparam logic [7:0] OP_READ   = 8'h00;
    localparam logic [7:0] OP_PSET   = 8'h40;
    localparam logic [7:0] OP_PVFY   = 8'hC0;
    localparam logic [7:0] OP_ESET   = 8'h20;
    localparam logic [7:0] OP_EVFY   = 8'hA0;
    localparam logic [7:0] OP_RESET  = 8'hFF;

endpackage

// File: rtl/flcmd_bus_sync.sv
// Bus strobe front end.
// Synchronizes chip-enable and write-enable into the clk domain and finds
// qualified write-enable edges. Assumes each strobe level lasts longer than
// SYNC_STAGES+1 clocks, and that address and data stay stable for that long
// after the edge that captures them.
module flcmd_bus_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic we_n,
    output logic addr_take,
    output logic wr_done
);

    logic [SYNC_STAGES-1:0] ce_sh;
    logic [SYNC_STAGES-1:0] we_sh;
    logic                   we_prev;
    logic                   cyc_open;
    logic                   ce_s;
    logic                   we_s;
    logic                   we_fall;
    logic                   we_rise;

    assign ce_s    = ce_sh[SYNC_STAGES-1];
    assign we_s    = we_sh[SYNC_STAGES-1];
    assign we_fall = we_prev & ~we_s;
    assign we_rise = ~we_prev & we_s;

    // Shift both strobes through the synchronizer chain; idle level is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_sh   <= '1;
            we_sh   <= '1;
            we_prev <= 1'b1;
        end else begin
            ce_sh   <= {ce_sh[SYNC_STAGES-2:0], ce_n};
            we_sh   <= {we_sh[SYNC_STAGES-2:0], we_n};
            we_prev <= we_s;
        end
    end

    // Track a write cycle that opened with chip-enable low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_open <= 1'b0;
        end else if (ce_s) begin
            cyc_open <= 1'b0;
        end else if (we_fall) begin
            cyc_open <= 1'b1;
        end else if (we_rise) begin
            cyc_open <= 1'b0;
        end
    end

    // Qualified edges used by the latches and the lane decoders.
    always_comb begin
        addr_take = we_fall & ~ce_s;
        wr_done   = we_rise & ~ce_s & cyc_open;
    end

endmodule

// File: rtl/flcmd_lane.sv
// One byte lane command decoder.
// Steps the lane mode on each completed write using that lane's byte.
// Issues one-cycle start pulses only while high voltage is present.
// A second consecutive FFH always returns the lane to read mode.
module flcmd_lane
    import flcmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_done,
    input  logic [7:0] cmd,
    input  logic       hv_ok,
    output flmode_e    mode,
    output logic       prog_start,
    output logic       erase_start,
    output logic       verify_sel
);

    flmode_e mode_nx;
    logic    ff_pend;
    logic    ps_nx;
    logic    es_nx;
    logic    is_ff;

    assign is_ff = (cmd == OP_RESET);

    // Next-mode decode for a completed write.
    always_comb begin
        mode_nx = mode;
        ps_nx   = 1'b0;
        es_nx   = 1'b0;
        if (ff_pend && is_ff) begin
            mode_nx = MD_READ;
        end else begin
            unique case (mode)
                MD_READ, MD_PVFY, MD_EVFY: begin
                    if (cmd == OP_PSET)      mode_nx = MD_PSET;
                    else if (cmd == OP_ESET) mode_nx = MD_ESET;
                    else if (cmd == OP_READ) mode_nx = MD_READ;
                end
                MD_PSET: begin
                    if (is_ff) begin
                        mode_nx = MD_READ;
                    end else if (hv_ok) begin
                        mode_nx = MD_PROG;
                        ps_nx   = 1'b1;
                    end else begin
                        mode_nx = MD_READ;
                    end
                end
                MD_PROG:  mode_nx = (cmd == OP_PVFY) ? MD_PVFY : MD_READ;
                MD_ESET: begin
                    if (cmd == OP_ESET && hv_ok) begin
                        mode_nx = MD_ERASE;
                        es_nx   = 1'b1;
                    end else begin
                        mode_nx = MD_READ;
                    end
                end
                MD_ERASE: mode_nx = (cmd == OP_EVFY) ? MD_EVFY : MD_READ;
                default:  mode_nx = MD_READ;
            endcase
        end
    end

    // Register mode, pending-reset flag and start pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode        <= MD_READ;
            ff_pend     <= 1'b0;
            prog_start  <= 1'b0;
            erase_start <= 1'b0;
        end else begin
            prog_start  <= wr_done & ps_nx;
            erase_start <= wr_done & es_nx;
            if (wr_done) begin
                mode    <= mode_nx;
                ff_pend <= is_ff & ~ff_pend;
            end
        end
    end

    // Margin-verify read select.
    always_comb begin
        verify_sel = (mode == MD_PVFY) || (mode == MD_EVFY);
    end

endmodule

// File: rtl/flcmd_top.sv
// Flash command interpreter top.
// Combines the strobe front end, the address and data latches and one
// command decoder per byte lane. The bus is 8*LANES bits wide.
module flcmd_top
    import flcmd_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int LANES       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ce_n,
    input  logic                 we_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [8*LANES-1:0]   bus_din,
    input  logic                 hv_ok,
    output logic [3*LANES-1:0]   lane_mode,
    output logic [LANES-1:0]     prog_start,
    output logic [LANES-1:0]     erase_start,
    output logic [LANES-1:0]     verify_sel,
    output logic [ADDR_W-1:0]    lat_addr,
    output logic [8*LANES-1:0]   lat_data
);

    localparam int DATA_W = 8 * LANES;

    logic addr_take;
    logic wr_done;

    flcmd_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .we_n      (we_n),
        .addr_take (addr_take),
        .wr_done   (wr_done)
    );

    // Capture address at the qualified fall, data at the completing rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr <= '0;
            lat_data <= '0;
        end else begin
            if (addr_take) lat_addr <= bus_addr;
            if (wr_done)   lat_data <= bus_din[DATA_W-1:0];
        end
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        flmode_e lmode;

        flcmd_lane u_lane (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_done     (wr_done),
            .cmd         (bus_din[8*k +: 8]),
            .hv_ok       (hv_ok),
            .mode        (lmode),
            .prog_start  (prog_start[k]),
            .erase_start (erase_start[k]),
            .verify_sel  (verify_sel[k])
        );

        assign lane_mode[3*k +: 3] = lmode;
    end

endmodule

// File: rtl/flcmd_chk.sv
// Property checker for the flash command interpreter, bound to the top.
module flcmd_chk #(
    parameter int LANES = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               hv_ok,
    input logic               wr_done,
    input logic [3*LANES-1:0] lane_mode,
    input logic [LANES-1:0]   prog_start,
    input logic [LANES-1:0]   erase_start
);

    for (genvar k = 0; k < LANES; k++) begin : g_chk
        assert_reset_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(rst_n) |-> lane_mode[3*k +: 3] == 3'd0);

        assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(wr_done) |-> $stable(lane_mode[3*k +: 3]));

        assert_prog_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
            prog_start[k] |-> (lane_mode[3*k +: 3] == 3'd2 && $past(lane_mode[3*k +: 3]) == 3'd1));

        assert_prog_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
            prog_start[k] |=> !prog_start[k]);

        assert_erase_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
            erase_start[k] |-> (lane_mode[3*k +: 3] == 3'd5 && $past(lane_mode[3*k +: 3]) == 3'd4));

        assert_hv_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (prog_start[k] || erase_start[k]) |-> $past(hv_ok));

        assert_legal_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
            lane_mode[3*k +: 3] != 3'd7);
    end

endmodule

bind flcmd_top flcmd_chk #(.LANES(LANES)) u_flcmd_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hv_ok       (hv_ok),
    .wr_done     (wr_done),
    .lane_mode   (lane_mode),
    .prog_start  (prog_start),
    .erase_start (erase_start)
);

// File: tb/test_flcmd_top.sv
module test_flcmd_top;

    localparam int ADDR_W = 12;
    localparam int LANES  = 2;
    localparam int DW     = 8 * LANES;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ce_n = 1'b1;
    logic              we_n = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DW-1:0]     bus_din = '0;
    logic              hv_ok = 1'b1;
    logic [3*LANES-1:0] lane_mode;
    logic [LANES-1:0]  prog_start;
    logic [LANES-1:0]  erase_start;
    logic [LANES-1:0]  verify_sel;
    logic [ADDR_W-1:0] lat_addr;
    logic [DW-1:0]     lat_data;

    flcmd_top #(.ADDR_W(ADDR_W), .LANES(LANES)) i_flcmd_top (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n),
        .bus_addr(bus_addr), .bus_din(bus_din), .hv_ok(hv_ok),
        .lane_mode(lane_mode), .prog_start(prog_start),
        .erase_start(erase_start), .verify_sel(verify_sel),
        .lat_addr(lat_addr), .lat_data(lat_data)
    );

    always #10ns clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // Expected state
    int              em [LANES];
    bit              ep [LANES];
    int              eps [LANES];
    int              ees [LANES];
    logic [ADDR_W-1:0] e_addr = '0;
    logic [DW-1:0]     e_data = '0;

    // Observed pulse totals
    int ops [LANES];
    int oes [LANES];

    always @(negedge clk) begin
        if (rst_n) begin
            for (int k = 0; k < LANES; k++) begin
                if (prog_start[k])  ops[k]++;
                if (erase_start[k]) oes[k]++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Reference step of one lane from the requirements
    function automatic void step(input int m, input bit p, input logic [7:0] b,
                                 input bit hv, output int nm, output bit np,
                                 output bit ps, output bit es);
        nm = m; ps = 0; es = 0;
        np = (b == 8'hFF) && !p;
        if (p && b == 8'hFF) begin
            nm = 0;
        end else begin
            case (m)
                0, 3, 6: begin
                    if (b == 8'h40)      nm = 1;
                    else if (b == 8'h20) nm = 4;
                    else if (b == 8'h00) nm = 0;
                end
                1: begin
                    if (b == 8'hFF) nm = 0;
                    else if (hv) begin nm = 2; ps = 1; end
                    else nm = 0;
                end
                2: nm = (b == 8'hC0) ? 3 : 0;
                4: begin
                    if (b == 8'h20 && hv) begin nm = 5; es = 1; end
                    else nm = 0;
                end
                5: nm = (b == 8'hA0) ? 6 : 0;
                default: nm = 0;
            endcase
        end
    endfunction

    task automatic check_all(input string req);
        for (int k = 0; k < LANES; k++) begin
            chk(lane_mode[3*k +: 3] == em[k][2:0], req, $sformatf("lane%0d mode", k),
                lane_mode[3*k +: 3], em[k]);
            chk(verify_sel[k] == (em[k] == 3 || em[k] == 6), "R8",
                $sformatf("lane%0d verify_sel", k), verify_sel[k], (em[k] == 3 || em[k] == 6));
            chk(ops[k] == eps[k], req, $sformatf("lane%0d prog pulses", k), ops[k], eps[k]);
            chk(oes[k] == ees[k], req, $sformatf("lane%0d erase pulses", k), oes[k], ees[k]);
        end
        chk(lat_addr == e_addr, "R3", "lat_addr", lat_addr, e_addr);
        chk(lat_data == e_data, "R3", "lat_data", lat_data, e_data);
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Full qualified write; address and data change between the edges
    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DW-1:0] d,
                            input bit hv, input string req);
        @(negedge clk);
        hv_ok = hv; ce_n = 0; bus_addr = a; bus_din = ~d;
        wait_clk(2);
        we_n = 0;
        wait_clk(6);
        bus_addr = ~a; bus_din = d;
        wait_clk(2);
        we_n = 1;
        wait_clk(6);
        ce_n = 1; bus_din = ~d;
        wait_clk(3);
        for (int k = 0; k < LANES; k++) begin
            int nm; bit np, ps, es;
            step(em[k], ep[k], d[8*k +: 8], hv, nm, np, ps, es);
            em[k] = nm; ep[k] = np;
            eps[k] += int'(ps); ees[k] += int'(es);
        end
        e_addr = a; e_data = d;
        check_all(req);
    endtask

    task automatic summary;
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20ns * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < LANES; k++) begin
            em[k] = 0; ep[k] = 0; eps[k] = 0; ees[k] = 0; ops[k] = 0; oes[k] = 0;
        end
        wait_clk(4);
        rst_n = 1;
        wait_clk(2);
        check_all("R1");

        // Program flow on both lanes
        do_write(12'h123, 16'h4040, 1, "R4");
        do_write(12'h456, 16'h5AA5, 1, "R4");
        do_write(12'h456, 16'hC0C0, 1, "R5");
        do_write(12'h000, 16'h0000, 1, "R8");
        // Erase flow
        do_write(12'h010, 16'h2020, 1, "R6");
        do_write(12'h010, 16'h2020, 1, "R6");
        do_write(12'h020, 16'hA0A0, 1, "R7");
        do_write(12'h020, 16'h3377, 1, "R12");
        // Wrong second erase byte, wrong end of program
        do_write(12'h030, 16'h2020, 1, "R6");
        do_write(12'h030, 16'h2120, 1, "R6");
        do_write(12'h031, 16'h4040, 1, "R4");
        do_write(12'h031, 16'h1111, 1, "R4");
        do_write(12'h032, 16'hA0A0, 1, "R5");
        // Lanes apart
        do_write(12'h040, 16'h2040, 1, "R11");
        do_write(12'h041, 16'h20EE, 1, "R11");
        do_write(12'h042, 16'hA0C0, 1, "R11");
        // FF cancels set-up, double FF resets active erase
        do_write(12'h050, 16'h4040, 1, "R4");
        do_write(12'h050, 16'hFFFF, 1, "R4");
        do_write(12'h051, 16'h2020, 1, "R9");
        do_write(12'h051, 16'h2020, 1, "R9");
        do_write(12'h052, 16'hFFFF, 1, "R9");
        do_write(12'h053, 16'hFFFF, 1, "R9");
        // No high voltage
        do_write(12'h060, 16'h4020, 1, "R10");
        do_write(12'h061, 16'h7720, 0, "R10");

        // Write-enable pulse with chip-enable high: nothing changes
        @(negedge clk);
        bus_addr = 12'hABC; bus_din = 16'h4040;
        wait_clk(2); we_n = 0; wait_clk(6); we_n = 1; wait_clk(6);
        check_all("R2");
        // Chip-enable rises before write-enable: only the address is taken
        ce_n = 0; bus_addr = 12'h5D1; bus_din = 16'h4040;
        wait_clk(2); we_n = 0; wait_clk(6); ce_n = 1; wait_clk(4);
        we_n = 1; wait_clk(6);
        e_addr = 12'h5D1;
        check_all("R2");

        // Random command streams
        for (int i = 0; i < 300; i++) begin
            logic [DW-1:0] d;
            for (int k = 0; k < LANES; k++) begin
                case ($urandom % 8)
                    0: d[8*k +: 8] = 8'h00;
                    1: d[8*k +: 8] = 8'h40;
                    2: d[8*k +: 8] = 8'h20;
                    3: d[8*k +: 8] = 8'hC0;
                    4: d[8*k +: 8] = 8'hA0;
                    5: d[8*k +: 8] = 8'hFF;
                    default: d[8*k +: 8] = 8'($urandom);
                endcase
            end
            do_write(ADDR_W'($urandom), d, ($urandom % 6) != 0, "R11");
        end
        summary();
    end

endmodule